// File: doc/BRIEF.md
# Program/Erase Completion Poller

This block sits on the host side of a byte-wide flash device. Once the host has sent a program or erase command sequence, it pulses `start` with the operation type, the status-checking method, the byte that was written and the target address. The poller then reads the device over a single-outstanding read channel until it can decide the result. It raises `done` for one cycle with a success or failure verdict and a reason code. On any failure it also pulses a request that asks the surrounding logic to send the device's reset command (F0h).

Two status methods are supported. The first is data polling, where bit 7 of the status byte tells busy from finished. The second is toggle checking, where bit 6 changes between back-to-back reads while the device is busy. Bit 5 is the device's timing-error flag. Bit 7 or bit 6 can settle in the same read in which bit 5 rises, so the poller re-examines the status once more before it declares a failure. After completion is seen, one confirming read must return the programmed byte, or FFh after an erase.

The read channel uses valid/ready handshakes. The request side holds `rd_req_valid` and `rd_addr` steady until `rd_req_ready` is seen high at a clock edge. After that, `rd_rsp_ready` stays high until the device side answers with `rd_rsp_valid`. The device side may stall either phase for any number of cycles.

Top module: `cmpl_poller`

## Requirements
- R1: A `start` pulse while idle captures `op_erase` (0 = program, 1 = erase), `use_toggle` (0 = data polling, 1 = toggle checking), `exp_byte` and `tgt_addr`, and sets `busy`. A `start` while `busy` is high has no effect on the run in progress or on `rd_addr`.
- R2: `rd_req_valid` stays high with a stable `rd_addr` until `rd_req_ready` is seen. After acceptance, `rd_rsp_ready` stays high until `rd_rsp_valid`. No new request is raised while a response is owed, so at most one read is outstanding.
- R3: In data-polling program mode, a status byte whose bit 7 equals `exp_byte[7]` and whose bit 5 is 0 means finished. A status byte with bit 7 inverted and bit 5 at 0 means busy, and polling continues.
- R4: In data-polling erase mode, bit 7 = 1 with bit 5 = 0 means finished, and bit 7 = 0 with bit 5 = 0 means busy.
- R5: In toggle mode, each check takes two consecutive reads. Equal bit 6 means finished. Differing bit 6 with bit 5 clear in both reads means busy.
- R6: If a check is not finished and bit 5 is 1, the poller re-checks: one more read in data-polling mode, or a fresh pair of reads in toggle mode. If the re-check shows completion, the poller proceeds to the confirming read. Otherwise the run fails with `err_code` = 1.
- R7: After completion, one confirming read must equal `exp_byte` (program) or FFh (erase). A mismatch fails the run with `err_code` = 2.
- R8: After `MAX_POLLS` busy checks without completion, the run fails with `err_code` = 3. That is exactly `MAX_POLLS` reads in data-polling mode and `2*MAX_POLLS` in toggle mode.
- R9: `done` is a one-cycle pulse. `success`, `fail` and `err_code` (0 = none) hold until the next accepted `start`. `rst_cmd` pulses together with `done` exactly when the run fails.
- R10: After reset, `busy`, `done`, `success`, `fail`, `rst_cmd`, `rd_req_valid` and `rd_rsp_ready` are 0, and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin polling (pulse) |
| op_erase | input | 1 | 0 = program, 1 = erase |
| use_toggle | input | 1 | 0 = data polling, 1 = toggle checking |
| exp_byte | input | 8 | Byte that was programmed |
| tgt_addr | input | ADDR_W | Address to poll |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle completion pulse |
| success | output | 1 | Last run succeeded |
| fail | output | 1 | Last run failed |
| err_code | output | 2 | 0 none, 1 status error, 2 confirm mismatch, 3 timeout |
| rst_cmd | output | 1 | Pulse: issue device reset command |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Read address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Poller waiting for read data |
| rd_rsp_data | input | 8 | Read data |

## Verification
Each method runs in both program and erase mode against a device model. The model returns a chosen number of busy status bytes and then the final data. This covers clean completion, whether or not the final byte happens to have bit 5 set. It also covers the case where bit 5 rises in the very read before completion, which must still end in success and separates the re-check from an immediate failure. A stuck device that keeps bit 5 set must fail with code 1 after a known read count. A silent stuck device must time out after exactly `MAX_POLLS` or `2*MAX_POLLS` reads. A corrupted final byte must be caught only by the confirming read. A second `start` in the middle of a run, carrying a different expected byte, must leave the verdict unchanged. Random handshake stalls on both read phases show that the verdict does not depend on latency.

// File: rtl/cp_pkg.sv
package cp_pkg;
  localparam int DATA_W  = 8;
  localparam int POLL_B  = 7;   // data-polling status bit
  localparam int TOG_B   = 6;   // toggling status bit
  localparam int FAULT_B = 5;   // device timing-error bit
  localparam logic [DATA_W-1:0] ERASED = '1;

  typedef enum logic [1:0] {
    CODE_NONE    = 2'd0,
    CODE_STATUS  = 2'd1,
    CODE_VERIFY  = 2'd2,
    CODE_TIMEOUT = 2'd3
  } code_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FIRST, ST_SECOND, ST_RCHK_A, ST_RCHK_B, ST_VERIFY
  } state_e;

  typedef enum logic [1:0] {RP_IDLE, RP_REQ, RP_WAIT} rp_state_e;
endpackage

// File: rtl/cp_read_port.sv
module cp_read_port
  import cp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              rsp_ready,
  input  logic              rsp_valid,
  output logic              got
);
  rp_state_e st;

  assign req_valid = (st == RP_REQ);
  assign rsp_ready = (st == RP_WAIT);
  assign got       = (st == RP_WAIT) && rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RP_IDLE;
    end else begin
      case (st)
        RP_IDLE: if (issue) st <= RP_REQ;
        RP_REQ:  if (req_ready) st <= RP_WAIT;
        RP_WAIT: if (rsp_valid) st <= issue ? RP_REQ : RP_IDLE;
        default: st <= RP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cp_status_eval.sv
module cp_status_eval
  import cp_pkg::*;
(
  input  logic              op_erase,
  input  logic [DATA_W-1:0] exp_byte,
  input  logic [DATA_W-1:0] cur,
  input  logic              prev_tog,
  input  logic              prev_fault,
  output logic              dp_done,
  output logic              tg_same,
  output logic              cur_fault,
  output logic              pair_fault,
  output logic              verify_ok
);
  logic [DATA_W-1:0] want;

  assign want       = op_erase ? ERASED : exp_byte;
  assign dp_done    = op_erase ? cur[POLL_B] : (cur[POLL_B] == exp_byte[POLL_B]);
  assign tg_same    = (cur[TOG_B] == prev_tog);
  assign cur_fault  = cur[FAULT_B];
  assign pair_fault = cur[FAULT_B] | prev_fault;
  assign verify_ok  = (cur == want);
endmodule

// File: rtl/cp_poll_limit.sv
module cp_poll_limit #(
  parameter int MAX_POLLS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST_V = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt;

  assign last = (cnt == LAST_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cmpl_poller.sv
module cmpl_poller
  import cp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MAX_POLLS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_erase,
  input  logic              use_toggle,
  input  logic [7:0]        exp_byte,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic              busy,
  output logic              done,
  output logic              success,
  output logic              fail,
  output logic [1:0]        err_code,
  output logic              rst_cmd,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [7:0]        rd_rsp_data
);
  state_e            st, nxt;
  logic              op_q, tog_q;
  logic [7:0]        exp_q;
  logic [ADDR_W-1:0] addr_q;
  logic              prev_tog_q, prev_fault_q;
  logic              done_q, success_q, rst_q;
  code_e             code_q, fin_code;
  logic              issue, got, fin, cnt_clr, cnt_inc, at_last;
  logic              dp_done, tg_same, cur_fault, pair_fault, verify_ok;

  cp_read_port u_port (
    .clk(clk), .rst_n(rst_n), .issue(issue),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready),
    .rsp_ready(rd_rsp_ready), .rsp_valid(rd_rsp_valid), .got(got)
  );

  cp_status_eval u_eval (
    .op_erase(op_q), .exp_byte(exp_q), .cur(rd_rsp_data),
    .prev_tog(prev_tog_q), .prev_fault(prev_fault_q),
    .dp_done(dp_done), .tg_same(tg_same), .cur_fault(cur_fault),
    .pair_fault(pair_fault), .verify_ok(verify_ok)
  );

  cp_poll_limit #(.MAX_POLLS(MAX_POLLS)) u_limit (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .last(at_last)
  );

  // one busy check seen: either give up or start the next check
  task automatic busy_check();
    if (at_last) begin
      fin      = 1'b1;
      fin_code = CODE_TIMEOUT;
    end else begin
      cnt_inc = 1'b1;
      issue   = 1'b1;
      nxt     = ST_FIRST;
    end
  endtask

  always_comb begin
    nxt      = st;
    issue    = 1'b0;
    fin      = 1'b0;
    fin_code = CODE_NONE;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        nxt = ST_FIRST; issue = 1'b1; cnt_clr = 1'b1;
      end
      ST_FIRST: if (got) begin
        if (tog_q) begin
          nxt = ST_SECOND; issue = 1'b1;
        end else if (dp_done && !cur_fault) begin
          nxt = ST_VERIFY; issue = 1'b1;
        end else if (cur_fault) begin
          nxt = ST_RCHK_B; issue = 1'b1;
        end else begin
          busy_check();
        end
      end
      ST_SECOND: if (got) begin
        if (tg_same) begin
          nxt = ST_VERIFY; issue = 1'b1;
        end else if (pair_fault) begin
          nxt = ST_RCHK_A; issue = 1'b1;
        end else begin
          busy_check();
        end
      end
      ST_RCHK_A: if (got) begin
        nxt = ST_RCHK_B; issue = 1'b1;
      end
      ST_RCHK_B: if (got) begin
        if (tog_q ? tg_same : dp_done) begin
          nxt = ST_VERIFY; issue = 1'b1;
        end else begin
          fin = 1'b1; fin_code = CODE_STATUS;
        end
      end
      ST_VERIFY: if (got) begin
        fin = 1'b1;
        fin_code = verify_ok ? CODE_NONE : CODE_VERIFY;
      end
      default: nxt = ST_IDLE;
    endcase
    if (fin) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      op_q         <= 1'b0;
      tog_q        <= 1'b0;
      exp_q        <= '0;
      addr_q       <= '0;
      prev_tog_q   <= 1'b0;
      prev_fault_q <= 1'b0;
      done_q       <= 1'b0;
      success_q    <= 1'b0;
      rst_q        <= 1'b0;
      code_q       <= CODE_NONE;
    end else begin
      st     <= nxt;
      done_q <= fin;
      rst_q  <= fin && (fin_code != CODE_NONE);
      if (st == ST_IDLE && start) begin
        op_q      <= op_erase;
        tog_q     <= use_toggle;
        exp_q     <= exp_byte;
        addr_q    <= tgt_addr;
        success_q <= 1'b0;
        code_q    <= CODE_NONE;
      end
      if (got) begin
        prev_tog_q   <= rd_rsp_data[TOG_B];
        prev_fault_q <= rd_rsp_data[FAULT_B];
      end
      if (fin) begin
        success_q <= (fin_code == CODE_NONE);
        code_q    <= fin_code;
      end
    end
  end

  assign busy     = (st != ST_IDLE);
  assign done     = done_q;
  assign success  = success_q;
  assign err_code = code_q;
  assign fail     = (code_q != CODE_NONE);
  assign rst_cmd  = rst_q;
  assign rd_addr  = addr_q;
endmodule

// File: rtl/cp_checker.sv
module cp_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              success,
  input logic [1:0]        err_code,
  input logic              rst_cmd,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_rsp_ready
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_addr)); // R2
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_ready |-> !rd_req_valid); // R2
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(rd_addr)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid && !rd_rsp_ready); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_RST_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |-> done && !success && err_code != 2'd0); // R9
  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done && success |-> err_code == 2'd0 && !rst_cmd); // R9
endmodule

bind cmpl_poller cp_checker #(.ADDR_W(ADDR_W)) u_cp_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .success(success),
  .err_code(err_code), .rst_cmd(rst_cmd), .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready), .rd_addr(rd_addr), .rd_rsp_ready(rd_rsp_ready)
);

// File: tb/test_cmpl_poller.sv
`timescale 1ns/1ps
module test_cmpl_poller;
  localparam int AW  = 16;
  localparam int MAX = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_erase = 1'b0, use_toggle = 1'b0;
  logic [7:0] exp_byte = '0;
  logic [AW-1:0] tgt_addr = '0;
  logic busy, done, success, fail, rst_cmd, rd_req_valid, rd_rsp_ready;
  logic [1:0] err_code;
  logic [AW-1:0] rd_addr;
  logic rd_req_ready = 1'b0, rd_rsp_valid = 1'b0;
  logic [7:0] rd_rsp_data = '0;

  int checks = 0, errors = 0;
  int m_k = 0, m_n = 0, m_kind = 0;
  bit m_op = 0, viol = 0;
  logic [7:0] m_exp = '0;
  logic [AW-1:0] m_addr = '0;

  always #10 clk = ~clk;

  cmpl_poller #(.ADDR_W(AW), .MAX_POLLS(MAX)) i_cmpl_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .use_toggle(use_toggle), .exp_byte(exp_byte), .tgt_addr(tgt_addr),
    .busy(busy), .done(done), .success(success), .fail(fail),
    .err_code(err_code), .rst_cmd(rst_cmd), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // device model: kinds 0 clean, 1 fault bit with late completion,
  // 2 corrupted result, 3 stuck with fault bit, 4 stuck silent
  function automatic logic [7:0] dev_byte(int k);
    logic [7:0] b;
    if (m_kind == 3 || m_kind == 4 || k < m_n) begin
      b    = 8'h0A;
      b[7] = m_op ? 1'b0 : ~m_exp[7];
      b[6] = k[0];
      b[5] = (m_kind == 3) || (m_kind == 1 && k == m_n - 1);
    end else begin
      b = m_op ? 8'hFF : m_exp;
      if (m_kind == 2) b = b ^ 8'h01;
    end
    return b;
  endfunction

  function automatic int exp_code(int kind);
    case (kind)
      2: return 2;
      3: return 1;
      4: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_reads(int kind, bit tog);
    if (kind == 3) return tog ? 4 : 2;
    return tog ? 2 * MAX : MAX;
  endfunction

  initial begin : device
    forever begin
      rd_req_ready = 1'b0;
      rd_rsp_valid = 1'b0;
      @(negedge clk);
      while (!rd_req_valid) @(negedge clk);
      if (rd_addr !== m_addr) viol = 1;
      repeat ($urandom % 3) @(negedge clk);
      rd_req_ready = 1'b1;
      @(negedge clk);
      rd_req_ready = 1'b0;
      for (int w = 0; w < int'($urandom % 3); w++) begin
        if (rd_req_valid || !rd_rsp_ready) viol = 1;
        @(negedge clk);
      end
      if (rd_req_valid || !rd_rsp_ready) viol = 1;
      rd_rsp_data  = dev_byte(m_k);
      rd_rsp_valid = 1'b1;
      m_k++;
      @(negedge clk);
      rd_rsp_valid = 1'b0;
    end
  end

  task automatic run(input bit op, input bit tog, input int n, input int kind,
                     input bit poke, input string tag);
    int ec;
    @(negedge clk);
    m_op = op; m_n = n; m_kind = kind; m_k = 0; viol = 0;
    m_exp = 8'($urandom); m_addr = AW'($urandom);
    op_erase = op; use_toggle = tog; exp_byte = m_exp; tgt_addr = m_addr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    if (poke) begin
      @(negedge clk);
      exp_byte = ~m_exp; op_erase = ~op; tgt_addr = ~m_addr;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    ec = exp_code(kind);
    chk(err_code == 2'(ec), {tag, " code"}, err_code, ec);
    chk(success == (ec == 0), {tag, " success R9"}, success, ec == 0);
    chk(rst_cmd == (ec != 0), {tag, " rst_cmd R9"}, rst_cmd, ec != 0);
    chk(viol == 0, {tag, " handshake R2"}, viol, 0);
    if (kind >= 3) chk(m_k == exp_reads(kind, tog), {tag, " read count"}, m_k, exp_reads(kind, tog));
    @(negedge clk);
    chk(done == 0 && rst_cmd == 0, {tag, " pulse width R9"}, {done, rst_cmd}, 0);
    chk(err_code == 2'(ec) && fail == (ec != 0) && !busy, {tag, " held R9"}, err_code, ec);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({busy, done, success, fail, rst_cmd, rd_req_valid, rd_rsp_ready} == 7'b0,
        "R10 reset outputs", {busy, done, success, fail, rst_cmd}, 0);
    chk(err_code == 2'd0, "R10 reset code", err_code, 0);
    rst_n = 1'b1;
    // directed corners
    run(0, 0, 3, 0, 0, "R3 dp program clean");
    run(1, 0, 2, 0, 0, "R4 dp erase clean");
    run(0, 1, 3, 0, 0, "R5 toggle program clean");
    run(1, 1, 0, 0, 0, "R5 toggle erase immediate");
    run(0, 0, 2, 1, 0, "R6 dp fault then done");
    run(1, 1, 3, 1, 0, "R6 toggle fault then done");
    run(0, 0, 1, 3, 0, "R6 dp stuck fault");
    run(1, 1, 1, 3, 0, "R6 toggle stuck fault");
    run(0, 0, 2, 2, 0, "R7 dp program mismatch");
    run(1, 1, 2, 2, 0, "R7 toggle erase mismatch");
    run(1, 0, 0, 4, 0, "R8 dp timeout");
    run(0, 1, 0, 4, 0, "R8 toggle timeout");
    run(0, 0, 3, 0, 1, "R1 start ignored while busy");
    // random mix
    for (int i = 0; i < 40; i++) begin
      int kind;
      int n;
      kind = int'($urandom % 5);
      n    = 1 + int'($urandom % 5);
      run(1'($urandom), 1'($urandom), n, kind, 0, "R3 R4 R5 R6 R7 R8 random");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule